// File: doc/BRIEF.md
# Programmable Memory Bank Address Decoder

This block turns a 32-bit system-bus address into a single bank select. Four external banks (two ROM/IO banks and two SDRAM banks) are placed in the map by software. Each bank holds a 13-bit base pointer and a 4-bit size code, loaded through a one-cycle write port. Two fixed regions at the top of the map, a small on-chip RAM and the on-chip peripheral space, always take precedence over any programmed bank.

The decode is combinational from the address and the current register contents. Alongside the one-hot select it gives a cacheable flag, taken from the address half, and an abort flag for addresses that no region claims. A bus master uses the select to steer the access, the cacheable flag to decide on caching, and the abort flag to end the transfer with an error.

Top module: `bank_addr_decoder`

## Requirements
- R1: After a synchronous reset every programmable bank is disabled (size code 0). Only the two fixed regions decode until software programs a bank.
- R2: A bank with size code c in 1..max starts at its 13-bit pointer shifted left by 18 bits. It spans 256 KB << (c-1) bytes and hits when start <= addr < start + span. Size code 0 disables the bank.
- R3: Size codes above a bank type's maximum are clamped to that maximum. Banks 0 and 1 (ROM/IO) stop at code 5 (4 MB). Banks 2 and 3 (SDRAM) stop at code 9 (64 MB).
- R4: When programmed banks overlap, the lowest-numbered hitting bank is selected.
- R5: Addresses 0xFFE0_0000 to 0xFFE0_0FFF select the on-chip RAM, which is bank_sel bit 1.
- R6: Addresses 0xFFF0_0000 to 0xFFFF_FFFF select the peripheral region, which is bank_sel bit 0. Addresses from 0xFFE0_0000 up are decoded only by the fixed regions, so 0xFFE0_1000 to 0xFFEF_FFFF hits nothing.
- R7: abort is 1 exactly when no bank_sel bit is set.
- R8: cacheable is 1 for addresses below 0x8000_0000 and 0 from 0x8000_0000 upward.
- R9: A write with wr_en high loads pointer and size into bank wr_idx at the next rising clock edge. During the write cycle the decode still uses the old contents.
- R10: bank_sel has at most one bit set. Bit 0 is peripherals, bit 1 is on-chip RAM, and bit 2+k is programmable bank k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Bank number to write |
| wr_ptr | input | 13 | Base pointer (256 KB units) |
| wr_size | input | 4 | Size code |
| addr | input | 32 | Bus address to decode |
| bank_sel | output | 6 | One-hot region select |
| cacheable | output | 1 | Address is in the cacheable half |
| abort | output | 1 | No region claims the address |

## Verification
A register write and a decode of the bank being rewritten can fall in the same cycle. The bench provokes this by removing a bank in the same cycle that it presents an address inside that bank. It checks that the select still names the bank before the clock edge and that abort rises after it. Overlap priority is judged on the same instant: the bank programmed first covers part of the second, and then the winner is disabled to show that the loser takes over.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int ADDR_W   = 32;
  localparam int PTR_W    = 13;
  localparam int SZ_W     = 4;
  localparam int GRAN_SH  = 18;
  localparam int N_FIXED  = 2;
  localparam int SEL_PERI = 0;
  localparam int SEL_RAM  = 1;
  localparam logic [ADDR_W-1:0] RAM_BASE  = 32'hFFE0_0000;
  localparam logic [ADDR_W-1:0] RAM_SPAN  = 32'h0000_1000;
  localparam logic [ADDR_W-1:0] PERI_BASE = 32'hFFF0_0000;
  localparam logic [ADDR_W-1:0] CACHE_LIM = 32'h8000_0000;
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int N_BANK = 4,
  parameter int PTR_W  = 13,
  parameter int SZ_W   = 4,
  localparam int IDX_W = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [PTR_W-1:0]         wr_ptr,
  input  logic [SZ_W-1:0]          wr_size,
  output logic [N_BANK*PTR_W-1:0]  ptr_o,
  output logic [N_BANK*SZ_W-1:0]   size_o
);
  logic [PTR_W-1:0] ptr_q  [N_BANK];
  logic [SZ_W-1:0]  size_q [N_BANK];

  for (genvar i = 0; i < N_BANK; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[i]  <= '0;
        size_q[i] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ptr_q[i]  <= wr_ptr;
        size_q[i] <= wr_size;
      end
    end
    assign ptr_o[i*PTR_W +: PTR_W] = ptr_q[i];
    assign size_o[i*SZ_W +: SZ_W]  = size_q[i];

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && wr_idx == IDX_W'(i) && !rst) |->
        (size_q[i] == $past(wr_size) && ptr_q[i] == $past(wr_ptr)));
  end

  // R1
  reset_disables_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (size_o == '0));
endmodule

// File: rtl/bank_range_match.sv
module bank_range_match #(
  parameter int N_BANK   = 4,
  parameter int N_ROM    = 2,
  parameter int ROM_MAXC = 5,
  parameter int SD_MAXC  = 9,
  parameter int ADDR_W   = 32,
  parameter int PTR_W    = 13,
  parameter int SZ_W     = 4,
  parameter int GRAN_SH  = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N_BANK*PTR_W-1:0]  ptr_i,
  input  logic [N_BANK*SZ_W-1:0]   size_i,
  output logic [N_BANK-1:0]        hit
);
  localparam int EXT_W = ADDR_W + 1;
  logic [EXT_W-1:0] addr_x;
  assign addr_x = {1'b0, addr};

  for (genvar i = 0; i < N_BANK; i++) begin : g_bank
    localparam int MAXC = (i < N_ROM) ? ROM_MAXC : SD_MAXC;
    logic [SZ_W-1:0]  code, eff;
    logic [EXT_W-1:0] base, span, lim;

    assign code = size_i[i*SZ_W +: SZ_W];
    assign eff  = (code > SZ_W'(MAXC)) ? SZ_W'(MAXC) : code;
    assign base = EXT_W'(ptr_i[i*PTR_W +: PTR_W]) << GRAN_SH;
    assign span = (eff == '0) ? '0 : (EXT_W'(1) << (GRAN_SH + int'(eff) - 1));
    assign lim  = base + span;
    assign hit[i] = (eff != '0) && (addr_x >= base) && (addr_x < lim);

    // R2
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (size_i[i*SZ_W +: SZ_W] == '0) |-> !hit[i]);
  end
endmodule

// File: rtl/bank_select_pri.sv
module bank_select_pri
  import bank_dec_pkg::*;
#(
  parameter int N_BANK = 4,
  localparam int NSEL  = N_BANK + N_FIXED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_BANK-1:0] hit,
  output logic [NSEL-1:0]   sel,
  output logic              abort_o
);
  logic in_top, in_ram, in_peri;
  assign in_top  = addr >= RAM_BASE;
  assign in_ram  = in_top && (addr < RAM_BASE + RAM_SPAN);
  assign in_peri = addr >= PERI_BASE;

  always_comb begin
    sel = '0;
    if (in_peri) begin
      sel[SEL_PERI] = 1'b1;
    end else if (in_ram) begin
      sel[SEL_RAM] = 1'b1;
    end else if (!in_top) begin
      for (int k = N_BANK - 1; k >= 0; k--) begin
        if (hit[k]) begin
          sel = '0;
          sel[N_FIXED + k] = 1'b1;
        end
      end
    end
  end

  assign abort_o = (sel == '0);

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  // R6
  top_fixed_only_chk: assert property (@(posedge clk) disable iff (rst)
    (addr >= RAM_BASE) |-> (sel[NSEL-1:N_FIXED] == '0));
  // R4
  low_bank_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && addr < RAM_BASE) |-> sel[N_FIXED]);
  // R7
  hit_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != '0 && addr < RAM_BASE) |-> !abort_o);
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bank_dec_pkg::*;
#(
  parameter int N_ROM    = 2,
  parameter int N_SDRAM  = 2,
  parameter int ROM_MAXC = 5,
  parameter int SD_MAXC  = 9,
  localparam int N_BANK  = N_ROM + N_SDRAM,
  localparam int IDX_W   = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int NSEL    = N_BANK + N_FIXED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   bank_sel,
  output logic              cacheable,
  output logic              abort
);
  logic [N_BANK*PTR_W-1:0] ptr_w;
  logic [N_BANK*SZ_W-1:0]  size_w;
  logic [N_BANK-1:0]       hit_w;

  bank_regfile #(.N_BANK(N_BANK), .PTR_W(PTR_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ptr(wr_ptr), .wr_size(wr_size), .ptr_o(ptr_w), .size_o(size_w)
  );

  bank_range_match #(
    .N_BANK(N_BANK), .N_ROM(N_ROM), .ROM_MAXC(ROM_MAXC), .SD_MAXC(SD_MAXC),
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .SZ_W(SZ_W), .GRAN_SH(GRAN_SH)
  ) u_match (
    .clk(clk), .rst(rst), .addr(addr), .ptr_i(ptr_w), .size_i(size_w), .hit(hit_w)
  );

  bank_select_pri #(.N_BANK(N_BANK)) u_pri (
    .clk(clk), .rst(rst), .addr(addr), .hit(hit_w), .sel(bank_sel), .abort_o(abort)
  );

  assign cacheable = addr < CACHE_LIM;

  // R8
  upper_half_uncached_chk: assert property (@(posedge clk) disable iff (rst)
    addr[ADDR_W-1] |-> !cacheable);
endmodule

// File: tb/bank_addr_decoder_tb.sv
module bank_addr_decoder_tb;
  typedef struct packed {
    logic [31:0] a;
    logic [5:0]  s;
    logic        ab;
    logic        c;
  } vec_t;

  // Map: bank0 0x0..0xFFFFF (code 3); bank1 0x80000..0x47FFFF (code 7 -> 5);
  // bank2 0x7FC00000..0x83BFFFFF (code 9); bank3 0x40000000..0x4007FFFF (code 2)
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 6'h04, 1'b0, 1'b1},
    '{32'h000F_FFFF, 6'h04, 1'b0, 1'b1},
    '{32'h0010_0000, 6'h08, 1'b0, 1'b1},
    '{32'h0008_0000, 6'h04, 1'b0, 1'b1},
    '{32'h0047_FFFF, 6'h08, 1'b0, 1'b1},
    '{32'h0048_0000, 6'h00, 1'b1, 1'b1},
    '{32'h7FC0_0000, 6'h10, 1'b0, 1'b1},
    '{32'h8000_0000, 6'h10, 1'b0, 1'b0},
    '{32'h83BF_FFFF, 6'h10, 1'b0, 1'b0},
    '{32'h83C0_0000, 6'h00, 1'b1, 1'b0},
    '{32'h4000_0000, 6'h20, 1'b0, 1'b1},
    '{32'h4007_FFFF, 6'h20, 1'b0, 1'b1},
    '{32'h4008_0000, 6'h00, 1'b1, 1'b1},
    '{32'hFFE0_0000, 6'h02, 1'b0, 1'b0},
    '{32'hFFE0_0FFF, 6'h02, 1'b0, 1'b0},
    '{32'hFFE0_1000, 6'h00, 1'b1, 1'b0},
    '{32'hFFEF_FFFF, 6'h00, 1'b1, 1'b0},
    '{32'hFFF0_0000, 6'h01, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 6'h01, 1'b0, 1'b0},
    '{32'h7FFF_FFFF, 6'h10, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [12:0] wr_ptr = '0;
  logic [3:0]  wr_size = '0;
  logic [31:0] addr = '0;
  logic [5:0]  bank_sel;
  logic        cacheable, abort;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_addr_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ptr(wr_ptr),
    .wr_size(wr_size), .addr(addr), .bank_sel(bank_sel),
    .cacheable(cacheable), .abort(abort)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got sel/abort/cache=%h expected=%h", tag, addr, got, exp);
    end
  endtask

  task automatic probe(input string tag, input logic [31:0] a,
                       input logic [5:0] s, input logic ab, input logic c);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, {bank_sel, abort, cacheable}, {s, ab, c});
  endtask

  task automatic wr(input logic [1:0] i, input logic [12:0] p, input logic [3:0] z);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_ptr = p; wr_size = z;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.ab)         return "R7";
    else if (v.s[0])  return "R6";
    else if (v.s[1])  return "R5";
    else if (v.a[31]) return "R8";
    else              return "R2";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: nothing programmed, only fixed regions answer
    probe("R1", 32'h0000_0000, 6'h00, 1'b1, 1'b1);
    probe("R1", 32'h4000_0000, 6'h00, 1'b1, 1'b1);
    probe("R1", 32'hFFF0_0000, 6'h01, 1'b0, 1'b0);

    wr(2'd0, 13'h0000, 4'd3);
    wr(2'd1, 13'h0002, 4'd7);   // R3 clamps to 4 MB
    wr(2'd2, 13'h1FF0, 4'd9);
    wr(2'd3, 13'h1000, 4'd2);

    for (int k = 0; k < NV; k++)
      probe(tag_of(VEC[k]), VEC[k].a, VEC[k].s, VEC[k].ab, VEC[k].c);

    // R4 overlap: 0x80000 is in banks 0 and 1
    probe("R4", 32'h0008_0000, 6'h04, 1'b0, 1'b1);
    // R3 clamp seen on bank1 end
    probe("R3", 32'h0048_0000, 6'h00, 1'b1, 1'b1);

    // R9 same-cycle write: disable bank3 while decoding inside it
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd3; wr_ptr = 13'h1000; wr_size = 4'd0;
    addr = 32'h4000_0000;
    #1;
    check("R9", {bank_sel, abort, cacheable}, {6'h20, 1'b0, 1'b1});
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R9", {bank_sel, abort, cacheable}, {6'h00, 1'b1, 1'b1});

    // R3 SDRAM code 15 clamps to 64 MB
    wr(2'd3, 13'h1000, 4'd15);
    probe("R3", 32'h43FF_FFFF, 6'h20, 1'b0, 1'b1);
    probe("R3", 32'h4400_0000, 6'h00, 1'b1, 1'b1);

    // R4 loser takes over once the winner is disabled
    wr(2'd0, 13'h0000, 4'd0);
    probe("R4", 32'h0008_0000, 6'h08, 1'b0, 1'b1);
    probe("R10", 32'h0000_0000, 6'h00, 1'b1, 1'b1);

    // R1 reset again clears all banks
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    probe("R1", 32'h7FC0_0000, 6'h00, 1'b1, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule